// File: doc/BRIEF.md
# Protected Reference Selector with Loss-of-Activity Alarm

This block sits in front of a line-card timing loop and picks which of two redundant, already-synchronized reference clocks the loop follows. The choice comes from an external switch input. It is honoured only once a timed start-up window after reset release has passed. Until then the first reference is used, and any low level seen on the switch input is recorded as an illegal setup.

The block watches only the reference that is currently selected. A watchdog counter runs in system-clock ticks and restarts on every rising edge of that reference. If roughly two and a half expected periods pass with no edge, the block raises a loss alarm and sends a one-cycle holdover request to the downstream loop. The expected period comes from a 4-bit frequency code. That code is sampled from configuration pins while the internal reset is held and applies to both references. When an edge arrives again, the alarm drops at once, with no qualification delay. A change of source restarts the watchdog, so a switchover does not raise a false alarm.

The alarm pin is modelled as an open-drain pair. When an alarm exists, the output is enabled and drives low. Otherwise the output enable is released.

Top module: `refSelMonitor`

## Requirements
- R1: After the start-up window, switch input high selects refA and low selects refB. `selRef` follows the chosen reference combinationally, one clock after the switch input changes.
- R2: For HOLD_TICKS+SETTLE_TICKS clocks after reset release, `selRef` is refA whatever the switch input does, and no alarm is raised.
- R3: A low switch input sampled inside the start-up window sets `illegalSetup`. The flag stays set until the next reset.
- R4: `freqCode` = {sonSdh, freqSel[2:0]} (bit 3 is sonSdh). It follows the pins during the first HOLD_TICKS clocks after reset release and is frozen afterwards.
- R5: The expected period is P = max(SYS_KHZ / f, 2) ticks, where f in kHz for freqSel 0..7 is 8, (sonSdh ? 1544 : 2048), 6480, 19440, 25920, 38880, 51840, 77760. The alarm is set on the clock when (5*P)/2 clocks have passed with no rising edge of the selected reference. It never sets while edges come at least once per P clocks.
- R6: `holdReq` is high for exactly one clock, the first clock of each alarm.
- R7: Edges or silence on the unselected reference have no effect on the alarm.
- R8: The alarm clears on the clock after the first rising edge of the selected reference, with no qualification period.
- R9: While the alarm exists, `alarmOe`=1 and `alarmN`=0. Otherwise `alarmOe`=0 and `alarmN`=1.
- R10: A change of selected source restarts the watchdog. The alarm is low on the next clock, and switching between two live references raises no alarm.
- R11: Asynchronous reset clears all state at once: no alarm, no holdover request, flag clear, code 0, refA selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refA | input | 1 | First reference, synchronized to clk |
| refB | input | 1 | Second reference, synchronized to clk |
| swIn | input | 1 | Source switch: high picks refA, low picks refB |
| freqSel | input | 3 | Expected-frequency select pins |
| sonSdh | input | 1 | Frequency family select pin |
| selRef | output | 1 | Currently selected reference |
| alarmN | output | 1 | Alarm level, low while alarm exists |
| alarmOe | output | 1 | Alarm output enable, high while alarm exists |
| holdReq | output | 1 | One-cycle holdover request to the loop |
| freqCode | output | 4 | Latched expected-frequency code |
| illegalSetup | output | 1 | Sticky flag for a low switch input during start-up |

## Verification
The assertions check, on every clock, the properties that can be expressed as properties:
- the sticky illegal-setup flag,
- the silent alarm while monitoring is off,
- the one-cycle holdover pulse,
- the immediate clear after an edge or a source change,
- the frozen code after the hold phase.

Only the bench scenarios can show the rest:
- the exact cycle at which the alarm rises for each frequency code,
- that silence on the unselected input goes unnoticed,
- that the mux follows the switch only after the window,
- that live switchovers never produce an alarm.

// File: rtl/refSelPkg.sv
package refSelPkg;

  typedef struct packed {
    logic latchCode;
    logic monitorEn;
    logic reload;
    logic selSecond;
  } selStrobe_t;

  function automatic int unsigned expPeriodTicks(input logic [3:0] code,
                                                 input int unsigned sysKhz);
    int unsigned fKhz;
    int unsigned p;
    case (code[2:0])
      3'd0: fKhz = 8;
      3'd1: fKhz = code[3] ? 1544 : 2048;
      3'd2: fKhz = 6480;
      3'd3: fKhz = 19440;
      3'd4: fKhz = 25920;
      3'd5: fKhz = 38880;
      3'd6: fKhz = 51840;
      default: fKhz = 77760;
    endcase
    p = sysKhz / fKhz;
    if (p < 2) p = 2;
    return p;
  endfunction

endpackage

// File: rtl/refSelCtrl.sv
module refSelCtrl
  import refSelPkg::*;
#(
  parameter int unsigned HOLD_TICKS   = 40,
  parameter int unsigned SETTLE_TICKS = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       swIn,
  output selStrobe_t strobe,
  output logic       illegalSetup
);
  localparam int unsigned WINDOW = HOLD_TICKS + SETTLE_TICKS;
  localparam int unsigned INIT_W = $clog2(WINDOW + 1);

  logic [INIT_W-1:0] initCnt;
  logic              windowDone;
  logic              selSecond;

  assign windowDone = (initCnt == INIT_W'(WINDOW));

  // start-up timer: hold phase then settle phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) initCnt <= '0;
    else if (!windowDone) initCnt <= initCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selSecond <= 1'b0;
    else if (windowDone) selSecond <= ~swIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) illegalSetup <= 1'b0;
    else if (!windowDone && !swIn) illegalSetup <= 1'b1;
  end

  always_comb begin
    strobe.latchCode = (initCnt < INIT_W'(HOLD_TICKS));
    strobe.monitorEn = windowDone;
    strobe.reload    = windowDone && ((~swIn) != selSecond);
    strobe.selSecond = selSecond;
  end

  // R3: illegal-setup flag is sticky until reset
  assert_sticky_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    illegalSetup |=> illegalSetup);

endmodule

// File: rtl/refSelPath.sv
module refSelPath
  import refSelPkg::*;
#(
  parameter int unsigned SYS_KHZ = 155520
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refA,
  input  logic       refB,
  input  logic [2:0] freqSel,
  input  logic       sonSdh,
  input  selStrobe_t strobe,
  output logic       selRef,
  output logic       alarm,
  output logic       holdReq,
  output logic [3:0] freqCode
);
  localparam int unsigned MAX_LIMIT = ((SYS_KHZ / 8) * 5) / 2 + 5;
  localparam int unsigned WD_W      = $clog2(MAX_LIMIT + 1);

  logic [WD_W-1:0] wdCnt;
  logic [WD_W-1:0] limitTicks;
  logic            prevA, prevB;
  logic            selRise;
  logic            alarmQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) freqCode <= '0;
    else if (strobe.latchCode) freqCode <= {sonSdh, freqSel};
  end

  always_comb limitTicks = WD_W'((expPeriodTicks(freqCode, SYS_KHZ) * 5) / 2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevA <= 1'b0;
      prevB <= 1'b0;
    end else begin
      prevA <= refA;
      prevB <= refB;
    end
  end

  assign selRef  = strobe.selSecond ? refB : refA;
  assign selRise = strobe.selSecond ? (refB & ~prevB) : (refA & ~prevA);

  // watchdog in system ticks since the last selected edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wdCnt <= '0;
    else if (!strobe.monitorEn || strobe.reload || selRise) wdCnt <= '0;
    else if (wdCnt < limitTicks) wdCnt <= wdCnt + 1'b1;
  end

  assign alarm = (wdCnt >= limitTicks);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) alarmQ <= 1'b0;
    else alarmQ <= alarm;
  end

  assign holdReq = alarm & ~alarmQ;

  // R2: no alarm while monitoring is off
  assert_quiet_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.monitorEn |=> !alarm);
  // R6: holdover request lasts a single clock
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    holdReq |=> !holdReq);
  // R8: an edge clears the alarm immediately
  assert_edge_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.monitorEn && selRise) |=> !alarm);
  // R10: a source change restarts the watchdog
  assert_switch_reload_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> !alarm);
  // R4: code frozen once the hold phase ends
  assert_code_frozen_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchCode |=> $stable(freqCode));

endmodule

// File: rtl/refSelMonitor.sv
module refSelMonitor
  import refSelPkg::*;
#(
  parameter int unsigned SYS_KHZ      = 155520,
  parameter int unsigned HOLD_TICKS   = SYS_KHZ * 250,
  parameter int unsigned SETTLE_TICKS = SYS_KHZ
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refA,
  input  logic       refB,
  input  logic       swIn,
  input  logic [2:0] freqSel,
  input  logic       sonSdh,
  output logic       selRef,
  output logic       alarmN,
  output logic       alarmOe,
  output logic       holdReq,
  output logic [3:0] freqCode,
  output logic       illegalSetup
);
  selStrobe_t strobe;
  logic       alarm;

  refSelCtrl #(.HOLD_TICKS(HOLD_TICKS), .SETTLE_TICKS(SETTLE_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .swIn(swIn),
    .strobe(strobe), .illegalSetup(illegalSetup)
  );

  refSelPath #(.SYS_KHZ(SYS_KHZ)) u_path (
    .clk(clk), .rstN(rstN), .refA(refA), .refB(refB),
    .freqSel(freqSel), .sonSdh(sonSdh), .strobe(strobe),
    .selRef(selRef), .alarm(alarm), .holdReq(holdReq), .freqCode(freqCode)
  );

  // R9: open-drain style alarm pin
  assign alarmOe = alarm;
  assign alarmN  = ~alarm;

endmodule

// File: tb/refSelMonitor_bench.sv
`timescale 1ns/1ps
module refSelMonitor_bench;
  localparam int unsigned SYS_KHZ = 7776;
  localparam int unsigned HOLD    = 40;
  localparam int unsigned SETTLE  = 10;
  localparam int unsigned WINDOW  = HOLD + SETTLE;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refA = 1'b0, refB = 1'b0, swIn = 1'b1, sonSdh = 1'b0;
  logic [2:0] freqSel = 3'd0;
  logic selRef, alarmN, alarmOe, holdReq, illegalSetup;
  logic [3:0] freqCode;

  int checkCount = 0, failCount = 0;
  bit enA = 1'b0, enB = 1'b0;
  int halfA = 1, halfB = 1;

  always #2.5 clk = ~clk;

  refSelMonitor #(.SYS_KHZ(SYS_KHZ), .HOLD_TICKS(HOLD), .SETTLE_TICKS(SETTLE)) u_refSelMonitor (
    .clk(clk), .rstN(rstN), .refA(refA), .refB(refB), .swIn(swIn),
    .freqSel(freqSel), .sonSdh(sonSdh), .selRef(selRef), .alarmN(alarmN),
    .alarmOe(alarmOe), .holdReq(holdReq), .freqCode(freqCode),
    .illegalSetup(illegalSetup)
  );

  initial begin : genA
    int c = 0;
    forever begin
      @(negedge clk);
      if (enA) begin
        c++;
        if (c >= halfA) begin c = 0; refA = ~refA; end
      end
    end
  end

  initial begin : genB
    int c = 0;
    forever begin
      @(negedge clk);
      if (enB) begin
        c++;
        if (c >= halfB) begin c = 0; refB = ~refB; end
      end
    end
  end

  function automatic int unsigned tbPeriod(input int fs, input bit son);
    int unsigned f, p;
    case (fs)
      0: f = 8;
      1: f = son ? 1544 : 2048;
      2: f = 6480;
      3: f = 19440;
      4: f = 25920;
      5: f = 38880;
      6: f = 51840;
      default: f = 77760;
    endcase
    p = SYS_KHZ / f;
    return (p < 2) ? 2 : p;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic doReset(input int fs, input bit son, input bit waitWindow);
    @(negedge clk);
    rstN = 1'b0; swIn = 1'b1; enA = 1'b0; enB = 1'b0;
    refA = 1'b0; refB = 1'b0; freqSel = 3'(fs); sonSdh = son;
    tick(2);
    chk(alarmOe == 0 && alarmN == 1 && holdReq == 0, "R11 alarm idle in reset", alarmOe, 0);
    chk(illegalSetup == 0 && freqCode == 0, "R11 flag/code cleared", freqCode, 0);
    @(negedge clk);
    rstN = 1'b1;
    if (waitWindow) begin
      tick(WINDOW + 2);
      chk(freqCode == {son, 3'(fs)}, "R4 latched code", freqCode, {son, 3'(fs)});
    end
  endtask

  task automatic noAlarmFor(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (alarmOe) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic windowScenario();
    doReset(3, 1'b0, 1'b0);
    refA = 1'b1; refB = 1'b0;
    tick(5);
    swIn = 1'b0;
    tick(5);
    chk(selRef == 1'b1, "R2 refA held in window", selRef, 1);
    chk(illegalSetup == 1'b1, "R3 low switch flagged", illegalSetup, 1);
    tick(30);
    chk(alarmOe == 1'b0, "R2 no alarm in window", alarmOe, 0);
    tick(WINDOW);
    chk(selRef == 1'b0, "R1 switch low selects refB", selRef, 0);
    swIn = 1'b1;
    tick(2);
    chk(selRef == 1'b1, "R1 switch high selects refA", selRef, 1);
    chk(illegalSetup == 1'b1, "R3 flag sticky", illegalSetup, 1);
    freqSel = 3'd7; sonSdh = 1'b1;
    tick(3);
    chk(freqCode == 4'b0011, "R4 later pin change ignored", freqCode, 3);
  endtask

  task automatic mainScenario(input int fs, input bit son);
    int unsigned p, lim;
    int mism;
    p = tbPeriod(fs, son);
    lim = (5 * p) / 2;
    doReset(fs, son, 1'b1);
    chk(illegalSetup == 1'b0, "R3 no flag when switch held high", illegalSetup, 0);
    halfA = int'(p / 2); halfB = int'(p / 2);
    enA = 1'b1;
    tick(1 + int'($urandom_range(0, 3)));
    enB = 1'b1;
    tick(int'(lim));
    noAlarmFor(int'(3 * lim), "R5 no alarm with live reference");
    mism = 0;
    for (int i = 0; i < 20; i++) begin tick(1); if (selRef != refA) mism++; end
    chk(mism == 0, "R1 selRef tracks refA", mism, 0);
    enB = 1'b0;
    noAlarmFor(int'(3 * lim), "R7 unselected silence ignored");
    enB = 1'b1;
    // stop refA right after a controlled rising edge
    enA = 1'b0; refA = 1'b0;
    tick(2);
    @(negedge clk); refA = 1'b1;
    tick(int'(lim));
    chk(alarmOe == 1'b0, "R5 no alarm before limit", alarmOe, 0);
    tick(1);
    chk(alarmOe == 1'b1 && alarmN == 1'b0, "R5/R9 alarm at limit", alarmOe, 1);
    chk(holdReq == 1'b1, "R6 holdover strobe", holdReq, 1);
    tick(1);
    chk(holdReq == 1'b0 && alarmOe == 1'b1, "R6 strobe one cycle", holdReq, 0);
    @(negedge clk); refA = 1'b0;
    tick(1);
    chk(alarmOe == 1'b1, "R8 alarm held without edge", alarmOe, 1);
    @(negedge clk); refA = 1'b1;
    tick(1);
    chk(alarmOe == 1'b0 && alarmN == 1'b1, "R8/R9 immediate clear", alarmOe, 0);
    tick(int'(lim) + 3);
    chk(alarmOe == 1'b1, "R5 alarm again", alarmOe, 1);
    @(negedge clk); swIn = 1'b0;
    tick(1);
    chk(alarmOe == 1'b0, "R10 switch restarts watchdog", alarmOe, 0);
    noAlarmFor(int'(3 * lim), "R10 live refB after switch");
    mism = 0;
    for (int i = 0; i < 20; i++) begin tick(1); if (selRef != refB) mism++; end
    chk(mism == 0, "R1 selRef tracks refB", mism, 0);
    enA = 1'b1;
    tick(int'(lim));
    @(negedge clk); swIn = 1'b1;
    noAlarmFor(int'(3 * lim), "R10 live switch back no alarm");
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checkCount++; failCount++;
    $display("FAIL watchdog run hung actual=1 expected=0");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin : stimulus
    void'($urandom(32'd2718));
    windowScenario();
    mainScenario(0, 1'b0);
    mainScenario(1, 1'b0);
    mainScenario(1, 1'b1);
    for (int k = 0; k < 6; k++) begin
      mainScenario(int'($urandom_range(1, 7)), 1'($urandom_range(0, 1)));
    end
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule